// File: doc/BRIEF.md
# Indexed Video Gate Array Register Block

This block holds the control state of a small video gate array. The CPU reaches most of it through one shared write port. An internal access toggle decides what each write on that port does. A write with the toggle clear selects a register index. A write with the toggle set stores the byte into the register that the index selects. Every write on the port inverts the toggle. A status-read strobe forces the toggle clear, so software can always return to a known phase before it starts a new index and data pair.

The indexed space holds the following registers:
- a primary mode control;
- a palette mask;
- a border colour;
- a secondary mode control;
- sixteen 4-bit palette entries.

From the two mode controls the block decodes the active video mode and the video-enable and blink flags. A separate page port sets three things:
- the display memory bank;
- the CPU memory bank;
- a two-bit line-interleave mask.

From the page port the block derives the two bank base addresses, the address shift and the address mask that the memory mapper applies. Pixel generation lies outside this block.

Top module: `vidgate_top`

## Requirements
- R1: After reset the block is in this state. The toggle is clear and the index is 0. The display-disable flag is 0. All palette entries, the border, the palette mask and both mode controls are 0, so the mode is text (code 0) and video and blink are off. The line mask is 0 and both banks are 7, which gives both bases 0x1C000, an address mask of 0x1FFFF and a shift of 0.
- R2: Each `port_wr` inverts the access toggle. With the toggle clear, the byte becomes the index. With the toggle set, the byte is written to the indexed register.
- R3: An index write drives `disp_off` to bit 4 of the written byte. Data writes leave `disp_off` and the index unchanged.
- R4: A data write to index 0x10+k (k from 0 to 15) stores the low 4 bits of the byte in palette entry k. Entry k appears on `pal_o[4k+3:4k]`.
- R5: A data write to index 0x01 stores all 8 bits in the palette mask. Index 0x02 stores the border. Index 0x03 stores the secondary mode control.
- R6: Index 0x00 is the primary mode control. Its bit 3 drives `video_en` and its bit 5 drives `blink_en`.
- R7: `vid_mode` is decoded in this priority order:
  - If primary bit 1 is 0, the mode is text (0).
  - Otherwise, if primary bit 4 is 1, the mode is 16-colour (3).
  - Otherwise, if secondary bit 3 is 1, the mode is 2-colour (1).
  - Otherwise the mode is 4-colour (2).
- R8: A `page_wr` loads the line mask from bits 7:6, the display bank from bits 2:0 and the CPU bank from bits 5:3. When line-mask bit 1 is 1, bit 0 of both banks is forced to 0.
- R9: Each bank base equals the bank number times 16384.
- R10: When the line mask is nonzero, `line_shift` is 13 and `addr_mask` is 0x1FFF. When it is zero, `line_shift` is 0 and `addr_mask` is 0x1FFFF.
- R11: `stat_rd` clears the toggle. A `port_wr` in the same cycle is handled as an index write and leaves the toggle set.
- R12: A data write to any index other than 0x00 to 0x03 or 0x10 to 0x1F changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_wr | input | 1 | Write strobe for the shared index/data port |
| page_wr | input | 1 | Write strobe for the page register |
| stat_rd | input | 1 | Status-read strobe; clears the access toggle |
| wdata | input | 8 | Write data for both ports |
| vid_mode | output | 2 | Decoded mode: 0 text, 1 two-colour, 2 four-colour, 3 sixteen-colour |
| video_en | output | 1 | Video enable |
| blink_en | output | 1 | Blink enable |
| disp_off | output | 1 | Display-disable flag taken from index bit 4 |
| pal_mask | output | 8 | Palette mask register |
| border | output | 8 | Border colour register |
| ctl2 | output | 8 | Secondary mode control register |
| pal_o | output | 64 | Sixteen 4-bit palette entries, entry 0 in the low bits |
| line_mask | output | 2 | Line-interleave mask |
| line_shift | output | 4 | Line shift amount (0 or 13) |
| addr_mask | output | 17 | Address mask for the memory mapper |
| disp_base | output | 17 | Display bank base address |
| cpu_base | output | 17 | CPU bank base address |

## Verification
The clocked properties treat the three strobes as single-cycle pulses that are sampled on the rising edge and never carry X or Z after reset. No other protocol is assumed: any mix of strobes in the same cycle, including a status read alongside a port write, is legal and defined.

The stimulus drives every input to a known value from time zero and changes the inputs only on falling edges. Most of the stimulus is random. The index it writes is usually a mapped one, and it also mixes in unmapped indexes, coincident status reads and page writes. A reference model tracks the toggle phase, so index writes and data writes both get plenty of coverage.

// File: rtl/vidgate_pkg.sv
package vidgate_pkg;

  typedef enum logic [1:0] {
    VM_TEXT  = 2'd0,
    VM_GFX2  = 2'd1,
    VM_GFX4  = 2'd2,
    VM_GFX16 = 2'd3
  } vmode_e;

  // bit positions inside the mode controls
  localparam int C1_GFX   = 1;
  localparam int C1_VID   = 3;
  localparam int C1_HI16  = 4;
  localparam int C1_BLINK = 5;
  localparam int C2_TWO   = 3;
  localparam int IDX_DOFF = 4;

  // fixed register indexes
  localparam int IX_CTL1  = 0;
  localparam int IX_PMASK = 1;
  localparam int IX_BORD  = 2;
  localparam int IX_CTL2  = 3;

  function automatic vmode_e decode_mode(input logic [7:0] c1, input logic [7:0] c2);
    if (!c1[C1_GFX])     return VM_TEXT;
    else if (c1[C1_HI16]) return VM_GFX16;
    else if (c2[C2_TWO])  return VM_GFX2;
    else                  return VM_GFX4;
  endfunction

endpackage

// File: rtl/vidgate_access.sv
module vidgate_access #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_wr,
  input  logic              stat_rd,
  input  logic [DATA_W-1:0] wdata,
  output logic              reg_we,
  output logic [DATA_W-1:0] reg_idx,
  output logic              disp_off
);
  import vidgate_pkg::*;

  logic              tog_q;
  logic              tog_eff;
  logic [DATA_W-1:0] idx_q;
  logic              doff_q;

  // a status read in the same cycle wins over the stored phase
  assign tog_eff = stat_rd ? 1'b0 : tog_q;
  assign reg_we  = port_wr && tog_eff;
  assign reg_idx = idx_q;
  assign disp_off = doff_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_q  <= 1'b0;
      idx_q  <= '0;
      doff_q <= 1'b0;
    end else begin
      if (port_wr)      tog_q <= !tog_eff;
      else if (stat_rd) tog_q <= 1'b0;
      if (port_wr && !tog_eff) begin
        idx_q  <= wdata;
        doff_q <= wdata[IDX_DOFF];
      end
    end
  end

  // R2
  tog_flip_chk: assert property (@(posedge clk) disable iff (rst)
    port_wr && !stat_rd |=> tog_q != $past(tog_q));

  // R11
  stat_clr_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd && !port_wr |=> !tog_q);

  // R11
  stat_wr_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd && port_wr |=> tog_q && idx_q == $past(wdata));

  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> $stable(idx_q) && $stable(doff_q));

endmodule

// File: rtl/vidgate_regfile.sv
module vidgate_regfile #(
  parameter int DATA_W   = 8,
  parameter int PAL_N    = 16,
  parameter int PAL_W    = 4,
  parameter int PAL_BASE = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_we,
  input  logic [DATA_W-1:0]       reg_idx,
  input  logic [DATA_W-1:0]       wdata,
  output logic [1:0]              vid_mode,
  output logic                    video_en,
  output logic                    blink_en,
  output logic [DATA_W-1:0]       pal_mask,
  output logic [DATA_W-1:0]       border,
  output logic [DATA_W-1:0]       ctl2,
  output logic [PAL_N*PAL_W-1:0]  pal_o
);
  import vidgate_pkg::*;

  localparam int SEL_W = (PAL_N > 1) ? $clog2(PAL_N) : 1;

  logic [DATA_W-1:0] ctl1_q, pmask_q, bord_q, ctl2_q;
  logic [PAL_W-1:0]  pal_mem [PAL_N];
  logic [DATA_W-1:0] pal_off;
  logic [SEL_W-1:0]  pal_sel;
  logic              pal_hit;
  logic              known;

  assign pal_off = reg_idx - DATA_W'(PAL_BASE);
  assign pal_sel = pal_off[SEL_W-1:0];
  assign pal_hit = (reg_idx >= DATA_W'(PAL_BASE)) && (pal_off < DATA_W'(PAL_N));
  assign known   = pal_hit || (reg_idx <= DATA_W'(IX_CTL2));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl1_q  <= '0;
      pmask_q <= '0;
      bord_q  <= '0;
      ctl2_q  <= '0;
    end else if (reg_we) begin
      case (reg_idx)
        DATA_W'(IX_CTL1):  ctl1_q  <= wdata;
        DATA_W'(IX_PMASK): pmask_q <= wdata;
        DATA_W'(IX_BORD):  bord_q  <= wdata;
        DATA_W'(IX_CTL2):  ctl2_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PAL_N; i++) pal_mem[i] <= '0;
    end else if (reg_we && pal_hit) begin
      pal_mem[pal_sel] <= wdata[PAL_W-1:0];
    end
  end

  generate
    for (genvar g = 0; g < PAL_N; g++) begin : g_pal
      assign pal_o[g*PAL_W +: PAL_W] = pal_mem[g];
    end
  endgenerate

  assign vid_mode = decode_mode(ctl1_q, ctl2_q);
  assign video_en = ctl1_q[C1_VID];
  assign blink_en = ctl1_q[C1_BLINK];
  assign pal_mask = pmask_q;
  assign border   = bord_q;
  assign ctl2     = ctl2_q;

  // R4
  pal_store_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we && pal_hit |=> pal_mem[$past(pal_sel)] == $past(wdata[PAL_W-1:0]));

  // R12
  unused_idx_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we && !known |=> $stable(ctl1_q) && $stable(pmask_q) && $stable(bord_q)
                         && $stable(ctl2_q) && $stable(pal_o));

  // R5
  bord_store_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we && reg_idx == DATA_W'(IX_BORD) |=> border == $past(wdata));

  // R7
  text_mode_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we && reg_idx == DATA_W'(IX_CTL1) && !wdata[C1_GFX] |=> vid_mode == VM_TEXT);

endmodule

// File: rtl/vidgate_page.sv
module vidgate_page #(
  parameter int DATA_W  = 8,
  parameter int BANK_W  = 3,
  parameter int BANK_SH = 14,
  parameter int ILV_SH  = 13,
  parameter int ADDR_W  = BANK_W + BANK_SH,
  parameter int SH_W    = $clog2(ILV_SH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              page_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [1:0]        line_mask,
  output logic [SH_W-1:0]   line_shift,
  output logic [ADDR_W-1:0] addr_mask,
  output logic [ADDR_W-1:0] disp_base,
  output logic [ADDR_W-1:0] cpu_base
);

  localparam logic [BANK_W-1:0] EVEN_M = {{(BANK_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] ILV_M  = ADDR_W'((1 << ILV_SH) - 1);

  logic [1:0]        lm_q, lm_d;
  logic [BANK_W-1:0] db_q, cb_q, bank_m;

  assign lm_d   = wdata[DATA_W-1 -: 2];
  assign bank_m = lm_d[1] ? EVEN_M : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      lm_q <= 2'b00;
      db_q <= '1;
      cb_q <= '1;
    end else if (page_wr) begin
      lm_q <= lm_d;
      db_q <= wdata[BANK_W-1:0] & bank_m;
      cb_q <= wdata[2*BANK_W-1:BANK_W] & bank_m;
    end
  end

  assign line_mask  = lm_q;
  assign line_shift = (lm_q != 2'b00) ? SH_W'(ILV_SH) : '0;
  assign addr_mask  = (lm_q != 2'b00) ? ILV_M : '1;
  assign disp_base  = {db_q, {BANK_SH{1'b0}}};
  assign cpu_base   = {cb_q, {BANK_SH{1'b0}}};

  // R8
  even_bank_chk: assert property (@(posedge clk) disable iff (rst)
    lm_q[1] |-> !db_q[0] && !cb_q[0]);

  // R8
  cpu_field_chk: assert property (@(posedge clk) disable iff (rst)
    page_wr |=> cb_q[BANK_W-1:1] == $past(wdata[2*BANK_W-1:BANK_W+1]));

  // R10
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !page_wr |=> $stable(lm_q) && $stable(db_q) && $stable(cb_q));

endmodule

// File: rtl/vidgate_top.sv
module vidgate_top #(
  parameter int DATA_W   = 8,
  parameter int PAL_N    = 16,
  parameter int PAL_W    = 4,
  parameter int PAL_BASE = 16,
  parameter int BANK_W   = 3,
  parameter int BANK_SH  = 14,
  parameter int ILV_SH   = 13
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           port_wr,
  input  logic                           page_wr,
  input  logic                           stat_rd,
  input  logic [DATA_W-1:0]              wdata,
  output logic [1:0]                     vid_mode,
  output logic                           video_en,
  output logic                           blink_en,
  output logic                           disp_off,
  output logic [DATA_W-1:0]              pal_mask,
  output logic [DATA_W-1:0]              border,
  output logic [DATA_W-1:0]              ctl2,
  output logic [PAL_N*PAL_W-1:0]         pal_o,
  output logic [1:0]                     line_mask,
  output logic [$clog2(ILV_SH+1)-1:0]    line_shift,
  output logic [BANK_W+BANK_SH-1:0]      addr_mask,
  output logic [BANK_W+BANK_SH-1:0]      disp_base,
  output logic [BANK_W+BANK_SH-1:0]      cpu_base
);

  localparam int ADDR_W = BANK_W + BANK_SH;
  localparam int SH_W   = $clog2(ILV_SH + 1);

  logic              reg_we;
  logic [DATA_W-1:0] reg_idx;

  vidgate_access #(.DATA_W(DATA_W)) u_acc (
    .clk(clk), .rst(rst), .port_wr(port_wr), .stat_rd(stat_rd), .wdata(wdata),
    .reg_we(reg_we), .reg_idx(reg_idx), .disp_off(disp_off)
  );

  vidgate_regfile #(.DATA_W(DATA_W), .PAL_N(PAL_N), .PAL_W(PAL_W), .PAL_BASE(PAL_BASE)) u_rf (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx), .wdata(wdata),
    .vid_mode(vid_mode), .video_en(video_en), .blink_en(blink_en),
    .pal_mask(pal_mask), .border(border), .ctl2(ctl2), .pal_o(pal_o)
  );

  vidgate_page #(.DATA_W(DATA_W), .BANK_W(BANK_W), .BANK_SH(BANK_SH), .ILV_SH(ILV_SH),
                 .ADDR_W(ADDR_W), .SH_W(SH_W)) u_pg (
    .clk(clk), .rst(rst), .page_wr(page_wr), .wdata(wdata),
    .line_mask(line_mask), .line_shift(line_shift), .addr_mask(addr_mask),
    .disp_base(disp_base), .cpu_base(cpu_base)
  );

endmodule

// File: tb/sim_vidgate_top.sv
`timescale 1ns/1ps
module sim_vidgate_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        port_wr = 1'b0, page_wr = 1'b0, stat_rd = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [1:0]  vid_mode;
  logic        video_en, blink_en, disp_off;
  logic [7:0]  pal_mask, border, ctl2;
  logic [63:0] pal_o;
  logic [1:0]  line_mask;
  logic [3:0]  line_shift;
  logic [16:0] addr_mask, disp_base, cpu_base;

  always #5 clk = ~clk;

  vidgate_top u0 (
    .clk(clk), .rst(rst), .port_wr(port_wr), .page_wr(page_wr), .stat_rd(stat_rd),
    .wdata(wdata), .vid_mode(vid_mode), .video_en(video_en), .blink_en(blink_en),
    .disp_off(disp_off), .pal_mask(pal_mask), .border(border), .ctl2(ctl2),
    .pal_o(pal_o), .line_mask(line_mask), .line_shift(line_shift),
    .addr_mask(addr_mask), .disp_base(disp_base), .cpu_base(cpu_base)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  bit         m_tog;
  logic [7:0] m_idx, m_c1, m_pm, m_bd, m_c2;
  bit         m_doff;
  logic [3:0] m_pal [16];
  logic [1:0] m_lm;
  logic [2:0] m_db, m_cb;

  function automatic logic [1:0] exp_mode(input logic [7:0] c1, input logic [7:0] c2);
    if (!c1[1]) return 2'd0;
    if (c1[4])  return 2'd3;
    if (c2[3])  return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [16:0] exp_base(input logic [2:0] b);
    return 17'(b) * 17'd16384;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_tog = 0; m_idx = 0; m_doff = 0;
    m_c1 = 0; m_pm = 0; m_bd = 0; m_c2 = 0;
    for (int i = 0; i < 16; i++) m_pal[i] = 0;
    m_lm = 0; m_db = 3'd7; m_cb = 3'd7;
  endtask

  task automatic cmp_all();
    chk("R7 vid_mode", 64'(vid_mode), 64'(exp_mode(m_c1, m_c2)));
    chk("R6 video_en", 64'(video_en), 64'(m_c1[3]));
    chk("R6 blink_en", 64'(blink_en), 64'(m_c1[5]));
    chk("R3 disp_off", 64'(disp_off), 64'(m_doff));
    chk("R5 pal_mask", 64'(pal_mask), 64'(m_pm));
    chk("R5 border", 64'(border), 64'(m_bd));
    chk("R5 ctl2", 64'(ctl2), 64'(m_c2));
    for (int k = 0; k < 16; k++) chk("R4 palette", 64'(pal_o[k*4 +: 4]), 64'(m_pal[k]));
    chk("R8 line_mask", 64'(line_mask), 64'(m_lm));
    chk("R9 disp_base", 64'(disp_base), 64'(exp_base(m_db)));
    chk("R9 cpu_base", 64'(cpu_base), 64'(exp_base(m_cb)));
    chk("R10 line_shift", 64'(line_shift), (m_lm != 0) ? 64'd13 : 64'd0);
    chk("R10 addr_mask", 64'(addr_mask), (m_lm != 0) ? 64'h1FFF : 64'h1FFFF);
  endtask

  task automatic step(input bit pw, input bit gw, input bit sr, input logic [7:0] d);
    @(negedge clk);
    port_wr = pw; page_wr = gw; stat_rd = sr; wdata = d;
    @(negedge clk);
    port_wr = 0; page_wr = 0; stat_rd = 0;
    if (sr) m_tog = 0;
    if (pw) begin
      if (!m_tog) begin
        m_idx = d; m_doff = d[4];
      end else begin
        case (m_idx)
          8'h00: m_c1 = d;
          8'h01: m_pm = d;
          8'h02: m_bd = d;
          8'h03: m_c2 = d;
          default: if (m_idx >= 8'h10 && m_idx <= 8'h1F) m_pal[m_idx[3:0]] = d[3:0];
        endcase
      end
      m_tog = !m_tog;
    end
    if (gw) begin
      m_lm = d[7:6];
      m_db = d[2:0] & (m_lm[1] ? 3'b110 : 3'b111);
      m_cb = d[5:3] & (m_lm[1] ? 3'b110 : 3'b111);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [7:0] ix;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    cmp_all();
    chk("R1 disp_base", 64'(disp_base), 64'h1C000);
    chk("R1 addr_mask", 64'(addr_mask), 64'h1FFFF);

    // R2 index then data
    step(1, 0, 0, 8'h02);
    step(1, 0, 0, 8'hA5);
    chk("R2 border", 64'(border), 64'hA5);
    // toggle back to index phase: R3 bit 4 sets disable, border unchanged
    step(1, 0, 0, 8'h5A);
    chk("R3 disp_off", 64'(disp_off), 64'd1);
    chk("R2 border", 64'(border), 64'hA5);

    // R11 status read resyncs: toggle now set, clear it
    step(0, 0, 1, 8'h00);
    step(1, 0, 0, 8'h02);
    step(1, 0, 0, 8'h33);
    chk("R11 border", 64'(border), 64'h33);
    // R11 coincident: toggle set, write+status goes to index
    step(1, 0, 0, 8'h01);
    step(1, 0, 1, 8'h01);
    step(1, 0, 0, 8'h77);
    chk("R11 pal_mask", 64'(pal_mask), 64'h77);
    chk("R11 border", 64'(border), 64'h33);

    // R12 unused index
    step(1, 0, 0, 8'h07);
    step(1, 0, 0, 8'hFF);
    cmp_all();
    step(1, 0, 0, 8'h20);
    step(1, 0, 0, 8'hFF);
    cmp_all();

    // R4 palette edges
    step(1, 0, 0, 8'h10); step(1, 0, 0, 8'hFE);
    step(1, 0, 0, 8'h1F); step(1, 0, 0, 8'h39);
    chk("R4 pal0", 64'(pal_o[3:0]), 64'hE);
    chk("R4 pal15", 64'(pal_o[63:60]), 64'h9);

    // R7 priority corners
    step(1, 0, 0, 8'h03); step(1, 0, 0, 8'h08);
    step(1, 0, 0, 8'h00); step(1, 0, 0, 8'h12);
    chk("R7 hi16 over two", 64'(vid_mode), 64'd3);
    step(1, 0, 0, 8'h00); step(1, 0, 0, 8'h2A);
    chk("R7 two-colour", 64'(vid_mode), 64'd1);
    chk("R6 video/blink", 64'({video_en, blink_en}), 64'b11);
    step(1, 0, 0, 8'h00); step(1, 0, 0, 8'h10);
    chk("R7 text", 64'(vid_mode), 64'd0);

    // R8/R9/R10 page corners
    step(0, 1, 0, 8'hFF);
    chk("R8 even disp", 64'(disp_base), 64'h18000);
    chk("R8 even cpu", 64'(cpu_base), 64'h18000);
    chk("R10 shift", 64'(line_shift), 64'd13);
    step(0, 1, 0, 8'h7F);
    chk("R8 odd kept", 64'(disp_base), 64'h1C000);
    chk("R10 mask", 64'(addr_mask), 64'h1FFF);
    step(0, 1, 0, 8'h0A);
    chk("R9 banks", 64'({cpu_base, disp_base}), 64'({17'h04000, 17'h08000}));
    chk("R10 mask full", 64'(addr_mask), 64'h1FFFF);
    cmp_all();

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom % 16;
      d = 8'($urandom);
      case ($urandom % 4)
        0: ix = 8'($urandom % 4);
        1: ix = 8'h10 | 8'($urandom % 16);
        2: ix = 8'($urandom);
        default: ix = 8'($urandom % 4) | (8'($urandom % 2) << 4);
      endcase
      if (r < 10)       step(1, 0, 0, m_tog ? d : ix);
      else if (r < 12)  step(0, 1, 0, d);
      else if (r < 13)  step(0, 0, 1, d);
      else if (r < 14)  step(1, 0, 1, ix);
      else              step(1, 1, 0, m_tog ? d : ix);
      cmp_all();
    end

    // R1 reset again mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    model_reset();
    cmp_all();
    finish_run();
  end

endmodule